// File: doc/BRIEF.md
# Condition Code Flag Evaluator

This block derives the four arithmetic status flags (negative, zero, carry, overflow) from the operands and the result of a 32-bit addition or subtraction. It keeps them in a small flag register and judges whether a 4-bit instruction condition field passes against the flags held there. The arithmetic is done elsewhere. The block receives both operands, the finished result and an add/subtract select. Carry and overflow come only from the sign bits of those three words, and the result word is also used to detect zero.

A write enable decides whether the freshly computed flags are loaded at the next clock edge. The condition verdict always uses the flags already held in the register. An instruction that both sets flags and is conditional is therefore judged on the flags that existed before it. The flag nibble is laid out as N, Z, C, V from its most significant bit down, which matches bits 31 to 28 of a status word.

Top module: `cond_flag_eval`

## Requirements
- R1: `flag_new[3]` (N) equals bit 31 of `result`.
- R2: `flag_new[2]` (Z) is 1 exactly when all 32 bits of `result` are zero.
- R3: When `is_sub`=0, `flag_new[1]` (C) is the unsigned carry out of `op_a + op_b`.
- R4: When `is_sub`=1, `flag_new[1]` (C) is the inverse of the unsigned borrow of `op_a - op_b`, so it is 1 when `op_a >= op_b` as unsigned numbers.
- R5: When `is_sub`=0, `flag_new[0]` (V) is 1 when the operands share a sign bit and the result's sign bit differs from it.
- R6: When `is_sub`=1, `flag_new[0]` (V) is 1 when the operand sign bits differ and the result's sign bit differs from that of `op_a`.
- R7: `flags` loads `flag_new` on a rising clock edge while `flag_we`=1 and holds its value on every other edge.
- R8: While `rst_n`=0, `flags` is 4'b0000.
- R9: Conditions 0x0 to 0x7 pass on Z=1, Z=0, C=1, C=0, N=1, N=0, V=1 and V=0, in that order.
- R10: Condition 0x8 passes when C=1 and Z=0. Condition 0x9 passes when C=0 or Z=1.
- R11: Condition 0xA passes when N=V, 0xB when N!=V, 0xC when Z=0 and N=V, and 0xD when Z=1 or N!=V.
- R12: Condition 0xE always passes and condition 0xF never passes.
- R13: `cond_pass` is judged on `flags` (the registered value). A flag write in the same cycle only affects the verdict from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand of the add or subtract |
| op_b | input | 32 | Second operand of the add or subtract |
| result | input | 32 | Result produced by the adder |
| is_sub | input | 1 | 1 for op_a - op_b, 0 for op_a + op_b |
| flag_we | input | 1 | Load the new flags at the next edge |
| cond | input | 4 | Condition field to evaluate |
| flag_new | output | 4 | Freshly computed flags {N,Z,C,V} |
| flags | output | 4 | Registered flags {N,Z,C,V} |
| cond_pass | output | 1 | Condition field passes on the registered flags |

## Verification
A flag update and a condition check can fall in the same cycle when a conditional instruction also sets the flags. The bench provokes this on every operation of its sweep. It raises `flag_we` while presenting a condition, checks that the verdict still follows the flags from the previous operation, and then checks after the edge that the verdict follows the new ones. Operands come from a set of sign and magnitude edge values, paired in both orders for addition and subtraction. All sixteen condition codes are then swept against each resulting flag state, with expected values computed by wide integer arithmetic.

// File: rtl/cond_flag_eval.sv
module cond_flag_eval #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] result,
  input  logic         is_sub,
  input  logic         flag_we,
  input  logic [3:0]   cond,
  output logic [3:0]   flag_new,
  output logic [3:0]   flags,
  output logic         cond_pass
);
  localparam int MSB = W - 1;

  logic sa, sb, sr;
  logic c_add, c_sub, v_add, v_sub;
  logic fn, fz, fc, fv;

  assign sa = op_a[MSB];
  assign sb = op_b[MSB];
  assign sr = result[MSB];

  assign c_add = (sa & sb) | ((sa | sb) & ~sr);
  assign c_sub = ~((~sa & sb) | ((~sa | sb) & sr));
  assign v_add = (sa == sb) & (sr != sa);
  assign v_sub = (sa != sb) & (sr != sa);

  assign flag_new = {sr, ~|result, is_sub ? c_sub : c_add, is_sub ? v_sub : v_add};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= 4'b0000;
    else if (flag_we) flags <= flag_new;
  end

  assign {fn, fz, fc, fv} = flags;

  always_comb begin
    case (cond)
      4'h0: cond_pass = fz;
      4'h1: cond_pass = ~fz;
      4'h2: cond_pass = fc;
      4'h3: cond_pass = ~fc;
      4'h4: cond_pass = fn;
      4'h5: cond_pass = ~fn;
      4'h6: cond_pass = fv;
      4'h7: cond_pass = ~fv;
      4'h8: cond_pass = fc & ~fz;
      4'h9: cond_pass = ~fc | fz;
      4'hA: cond_pass = (fn == fv);
      4'hB: cond_pass = (fn != fv);
      4'hC: cond_pass = ~fz & (fn == fv);
      4'hD: cond_pass = fz | (fn != fv);
      4'hE: cond_pass = 1'b1;
      default: cond_pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_flag_eval_chk.sv
module cond_flag_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_we,
  input logic [3:0] cond,
  input logic [3:0] flag_new,
  input logic [3:0] flags,
  input logic       cond_pass
);
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags == $past(flag_new));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));
  p_always_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'hE |-> cond_pass);
  p_never_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'hF |-> !cond_pass);
  p_eq_reg_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'h0 |-> cond_pass == flags[2]);
endmodule

bind cond_flag_eval cond_flag_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .cond(cond),
  .flag_new(flag_new), .flags(flags), .cond_pass(cond_pass)
);

// File: tb/test_cond_flag_eval.sv
`timescale 1ns/1ps
module test_cond_flag_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, result = '0;
  logic        is_sub = 1'b0, flag_we = 1'b0;
  logic [3:0]  cond = 4'h0;
  logic [3:0]  flag_new, flags;
  logic        cond_pass;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'h4000_0000};

  cond_flag_eval i_cond_flag_eval (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result),
    .is_sub(is_sub), .flag_we(flag_we), .cond(cond),
    .flag_new(flag_new), .flags(flags), .cond_pass(cond_pass)
  );

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;        4'h1: return !z;
      4'h2: return cy;       4'h3: return !cy;
      4'h4: return n;        4'h5: return !n;
      4'h6: return v;        4'h7: return !v;
      4'h8: return cy && !z; 4'h9: return !cy || z;
      4'hA: return n == v;   4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_req(input logic [3:0] c);
    if (c <= 4'h7) return "R9";
    if (c <= 4'h9) return "R10";
    if (c <= 4'hD) return "R11";
    return "R12";
  endfunction

  function automatic logic [3:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic [32:0] wide;
    longint s;
    logic [31:0] r;
    logic cy, v;
    if (sub) begin
      r  = a - b;
      cy = (a >= b);
      s  = longint'($signed(a)) - longint'($signed(b));
    end else begin
      wide = {1'b0, a} + {1'b0, b};
      r  = wide[31:0];
      cy = wide[32];
      s  = longint'($signed(a)) + longint'($signed(b));
    end
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    return {r[31], r == 32'h0, cy, v};
  endfunction

  initial begin
    logic [3:0] prev, expf;
    #1;
    check("R8 reset flags", {28'h0, flags}, 32'h0);
    cond = 4'h1; #1;
    check("R8 reset NE pass", {31'h0, cond_pass}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
    prev = 4'b0000;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          @(negedge clk);
          op_a = vals[i]; op_b = vals[j]; is_sub = s[0];
          result = is_sub ? op_a - op_b : op_a + op_b;
          expf = model(op_a, op_b, is_sub);
          flag_we = 1'b1;
          cond = 4'((i + j) % 15);
          #1;
          check("R1 N", {31'h0, flag_new[3]}, {31'h0, expf[3]});
          check("R2 Z", {31'h0, flag_new[2]}, {31'h0, expf[2]});
          check(is_sub ? "R4 C sub" : "R3 C add", {31'h0, flag_new[1]}, {31'h0, expf[1]});
          check(is_sub ? "R6 V sub" : "R5 V add", {31'h0, flag_new[0]}, {31'h0, expf[0]});
          check("R13 same-cycle verdict on old flags", {31'h0, cond_pass}, {31'h0, exp_cond(cond, prev)});
          @(negedge clk);
          flag_we = 1'b0;
          #1;
          check("R7 load", {28'h0, flags}, {28'h0, expf});
          check("R13 verdict after write", {31'h0, cond_pass}, {31'h0, exp_cond(cond, expf)});
          for (int c = 0; c < 16; c++) begin
            cond = 4'(c); #0.5;
            check(cond_req(cond), {31'h0, cond_pass}, {31'h0, exp_cond(cond, expf)});
          end
          op_a = ~op_a; op_b = 32'h1234_5678; result = 32'h0; is_sub = ~is_sub;
          @(negedge clk); #1;
          check("R7 hold without write", {28'h0, flags}, {28'h0, expf});
          prev = expf;
        end
      end
    end
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R8 reset again", {28'h0, flags}, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule